// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels gets the system bus next. Each channel raises a request line, and a per-channel enable bit screens that request. When at least one screened request is pending, the arbiter asks the bus-hold logic for the bus. It then waits until the processor answers with a grant. Only after that grant does it pick one channel and drive that channel's acknowledge line.

Two priority schemes are available, and a mode input selects between them at run time. In the fixed scheme the lowest channel number always wins. In the rotating scheme the search starts just after the channel that was serviced last, so every requester gets a turn. A granted channel keeps the bus for as long as it holds its request. Arbitration happens again only after that grant has ended and the arbiter has passed through idle.

Top module: `dma_prio_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, `bus_hold_req` is 0 and `chan_ack` is all zeros.
- R2: From idle, if any channel has both `chan_req` and `chan_en` high at a clock edge, `bus_hold_req` is 1 after that edge.
- R3: A channel whose `chan_en` bit is 0 never receives an acknowledge, and its request alone never raises `bus_hold_req`.
- R4: `chan_ack` stays all zeros until `bus_hold_grant` has been sampled high while a request is pending. The acknowledge appears in the cycle after that edge.
- R5: With `rotate_mode` = 0, the acknowledged channel is the lowest-numbered channel whose request and enable are both high. Bit i of `chan_ack` stands for channel i.
- R6: With `rotate_mode` = 1, the search starts at the channel after the one serviced last and goes up in number, wrapping from 3 to 0. The first pending enabled channel found wins. The last serviced channel is recorded when each grant ends, in either mode. After reset it is taken to be channel 3, so channel 0 is searched first.
- R7: While a grant is active, `chan_ack` does not change. Changes on other requests, on the enables or on `rotate_mode` have no effect on it.
- R8: The grant ends when the granted channel's request, or `bus_hold_grant`, is sampled low at a clock edge. After that edge `chan_ack` and `bus_hold_req` are both 0 for at least one cycle.
- R9: At most one bit of `chan_ack` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req | input | 4 | Per-channel DMA request |
| chan_en | input | 4 | Per-channel enable mask |
| rotate_mode | input | 1 | 1 = rotating priority, 0 = fixed priority |
| bus_hold_grant | input | 1 | Processor's answer to the hold request |
| bus_hold_req | output | 1 | Request for the bus toward the hold logic |
| chan_ack | output | 4 | One-hot channel acknowledge |

## Verification
The bench builds the block with its default of four channels, which keeps the full input space small. It covers every combination of the 16 request patterns, the 16 enable masks, both priority modes and all four last-serviced channels. Each combination is set up by first servicing the chosen channel. This reaches every rotation start point against every pending set, the all-masked cases, and the wrap from channel 3 to channel 0.

// File: rtl/dma_prio_pkg.sv
// Package: shared types for the DMA priority arbiter.
// Assumes: nothing beyond standard SystemVerilog.
package dma_prio_pkg;

    // Phases of one arbitration cycle: idle, waiting for the bus, granted.
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_WAIT  = 2'd1,
        ARB_GRANT = 2'd2
    } arb_phase_e;

endpackage

// File: rtl/dma_req_mask.sv
// Module: dma_req_mask
// Screens each channel request with its enable bit.
// Assumes: request and enable are synchronous to the arbiter clock.
module dma_req_mask #(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0] chan_req,
    input  logic [N_CH-1:0] chan_en,
    output logic [N_CH-1:0] pend
);

    // One gate per channel: a request counts only when its channel is enabled.
    for (genvar g = 0; g < N_CH; g++) begin : g_mask
        assign pend[g] = chan_req[g] & chan_en[g];
    end

endmodule

// File: rtl/dma_prio_pick.sv
// Module: dma_prio_pick
// Combinational winner selection among pending channels. In fixed mode
// the search starts at channel 0; in rotating mode it starts just after
// the last serviced channel and wraps.
// Assumes: last_idx < N_CH.
module dma_prio_pick #(
    parameter int N_CH = 4,
    localparam int IW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] pend,
    input  logic [IW-1:0]   last_idx,
    input  logic            rotate,
    output logic            win_valid,
    output logic [IW-1:0]   win_idx,
    output logic [N_CH-1:0] win_vec
);

    localparam logic [N_CH-1:0] ONE_HOT0 = {{(N_CH-1){1'b0}}, 1'b1};

    int start_pos;

    // Start position of the search: 0, or the channel after the last one serviced.
    always_comb begin
        if (rotate && (int'(last_idx) < N_CH - 1)) begin
            start_pos = int'(last_idx) + 1;
        end else begin
            start_pos = 0;
        end
    end

    // Walk the channels from the start position and take the first pending one.
    always_comb begin
        int cand;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int off = 0; off < N_CH; off++) begin
            cand = start_pos + off;
            if (cand >= N_CH) begin
                cand = cand - N_CH;
            end
            if (!win_valid && pend[cand]) begin
                win_valid = 1'b1;
                win_idx   = IW'(cand);
            end
        end
    end

    // Turn the winning index into a one-hot vector.
    assign win_vec = win_valid ? (ONE_HOT0 << win_idx) : '0;

endmodule

// File: rtl/dma_grant_fsm.sv
// Module: dma_grant_fsm
// Sequences the hold request, the wait for the bus grant, and the locked
// channel grant. Records the last serviced channel when a grant ends.
// Assumes: win_* reflect pend under the current last_idx.
module dma_grant_fsm
    import dma_prio_pkg::*;
#(
    parameter int N_CH = 4,
    localparam int IW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pend,
    input  logic [N_CH-1:0] chan_req,
    input  logic            bus_hold_grant,
    input  logic            win_valid,
    input  logic [IW-1:0]   win_idx,
    input  logic [N_CH-1:0] win_vec,
    output logic            bus_hold_req,
    output logic [N_CH-1:0] chan_ack,
    output logic [IW-1:0]   last_idx
);

    arb_phase_e      phase_q;
    logic [N_CH-1:0] grant_vec_q;
    logic [IW-1:0]   grant_idx_q;
    logic            grant_end;

    // A grant ends when its channel drops the request or the bus is taken back.
    assign grant_end = !chan_req[grant_idx_q] || !bus_hold_grant;

    // Phase register, locked grant, and record of the last serviced channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= ARB_IDLE;
            grant_vec_q <= '0;
            grant_idx_q <= '0;
            last_idx    <= IW'(N_CH - 1);
        end else begin
            case (phase_q)
                ARB_IDLE: begin
                    if (|pend) begin
                        phase_q <= ARB_WAIT;
                    end
                end
                ARB_WAIT: begin
                    if (!(|pend)) begin
                        phase_q <= ARB_IDLE;
                    end else if (bus_hold_grant && win_valid) begin
                        phase_q     <= ARB_GRANT;
                        grant_vec_q <= win_vec;
                        grant_idx_q <= win_idx;
                    end
                end
                ARB_GRANT: begin
                    if (grant_end) begin
                        phase_q     <= ARB_IDLE;
                        grant_vec_q <= '0;
                        last_idx    <= grant_idx_q;
                    end
                end
                default: phase_q <= ARB_IDLE;
            endcase
        end
    end

    // Outputs follow the phase: hold is requested outside idle, ack only when granted.
    assign bus_hold_req = (phase_q != ARB_IDLE);
    assign chan_ack     = (phase_q == ARB_GRANT) ? grant_vec_q : '0;

endmodule

// File: rtl/dma_prio_resolver.sv
// Module: dma_prio_resolver (top)
// Four-channel (by default) DMA arbiter with fixed or rotating priority.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module dma_prio_resolver #(
    parameter int N_CH = 4,
    localparam int IW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_req,
    input  logic [N_CH-1:0] chan_en,
    input  logic            rotate_mode,
    input  logic            bus_hold_grant,
    output logic            bus_hold_req,
    output logic [N_CH-1:0] chan_ack
);

    logic [N_CH-1:0] pend;
    logic            win_valid;
    logic [IW-1:0]   win_idx;
    logic [N_CH-1:0] win_vec;
    logic [IW-1:0]   last_idx;

    dma_req_mask #(.N_CH(N_CH)) mask_i (
        .chan_req (chan_req),
        .chan_en  (chan_en),
        .pend     (pend)
    );

    dma_prio_pick #(.N_CH(N_CH)) pick_i (
        .pend      (pend),
        .last_idx  (last_idx),
        .rotate    (rotate_mode),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_vec   (win_vec)
    );

    dma_grant_fsm #(.N_CH(N_CH)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pend           (pend),
        .chan_req       (chan_req),
        .bus_hold_grant (bus_hold_grant),
        .win_valid      (win_valid),
        .win_idx        (win_idx),
        .win_vec        (win_vec),
        .bus_hold_req   (bus_hold_req),
        .chan_ack       (chan_ack),
        .last_idx       (last_idx)
    );

endmodule

// File: rtl/dma_prio_resolver_chk.sv
// Module: dma_prio_resolver_chk
// Port-level properties of the arbiter, bound to the top module.
// Assumes: synchronous active-low reset.
module dma_prio_resolver_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] chan_req,
    input logic [N_CH-1:0] chan_en,
    input logic            rotate_mode,
    input logic            bus_hold_grant,
    input logic            bus_hold_req,
    input logic [N_CH-1:0] chan_ack
);

    p_onehot_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_ack));

    p_ack_under_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_ack) |-> bus_hold_req);

    p_ack_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|chan_ack) |-> $past(bus_hold_grant));

    p_ack_enabled_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|chan_ack) |-> (|(chan_ack & $past(chan_req & chan_en))));

    p_fixed_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|chan_ack) && !$past(rotate_mode))
        |-> (((chan_ack - 1'b1) & $past(chan_req & chan_en)) == '0));

    p_grant_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_ack) && (|$past(chan_ack))) |-> (chan_ack == $past(chan_ack)));

    p_hold_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hold_req) |-> $past(|(chan_req & chan_en)));

    p_release_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(chan_ack)) && !$past(bus_hold_grant)) |-> (chan_ack == '0));

endmodule

bind dma_prio_resolver dma_prio_resolver_chk #(.N_CH(N_CH)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .chan_req       (chan_req),
    .chan_en        (chan_en),
    .rotate_mode    (rotate_mode),
    .bus_hold_grant (bus_hold_grant),
    .bus_hold_req   (bus_hold_req),
    .chan_ack       (chan_ack)
);

// File: tb/dma_prio_resolver_tb_top.sv
module dma_prio_resolver_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan_req = '0;
    logic [3:0] chan_en = '0;
    logic       rotate_mode = 1'b0;
    logic       bus_hold_grant = 1'b0;
    logic       bus_hold_req;
    logic [3:0] chan_ack;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_prio_resolver #(.N_CH(4)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .chan_req       (chan_req),
        .chan_en        (chan_en),
        .rotate_mode    (rotate_mode),
        .bus_hold_grant (bus_hold_grant),
        .bus_hold_req   (bus_hold_req),
        .chan_ack       (chan_ack)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference winner from the requirements: R5 fixed, R6 rotating.
    function automatic logic [3:0] ref_winner(input logic [3:0] m, input bit rot, input int last);
        int s;
        s = rot ? (last + 1) % 4 : 0;
        for (int k = 0; k < 4; k++) begin
            if (m[(s + k) % 4]) return 4'(1 << ((s + k) % 4));
        end
        return 4'b0;
    endfunction

    task automatic one_case(input bit rot, input int last, input logic [3:0] en, input logic [3:0] rq);
        logic [3:0] m;
        logic [3:0] exp;
        string rtag;
        m    = rq & en;
        exp  = ref_winner(m, rot, last);
        rtag = rot ? "R6" : "R5";
        // Prepare: service channel 'last' in fixed mode so it becomes the last serviced one.
        chan_en = 4'hF; rotate_mode = 1'b0; chan_req = 4'(1 << last);
        step();
        bus_hold_grant = 1'b1;
        step();
        chk("R5", "prep ack", int'(chan_ack), 1 << last);
        chan_req = '0;
        step();
        bus_hold_grant = 1'b0;
        step();
        // Main arbitration.
        rotate_mode = rot; chan_en = en; chan_req = rq;
        step();
        chk(m != 0 ? "R2" : "R3", "hold_req", int'(bus_hold_req), int'(m != 0));
        chk("R4", "ack before grant", int'(chan_ack), 0);
        step();
        chk("R4", "ack still waiting", int'(chan_ack), 0);
        bus_hold_grant = 1'b1;
        step();
        chk(m != 0 ? rtag : "R3", "winner", int'(chan_ack), int'(exp));
        chk("R9", "onehot", $countones(chan_ack) <= 1, 1);
        if (m != 0) begin
            // R7: disturb the other inputs; the grant must not move.
            chan_req = 4'hF; rotate_mode = !rot; chan_en = ~en;
            step();
            chk("R7", "locked ack", int'(chan_ack), int'(exp));
            rotate_mode = rot;
            // R8: the granted channel drops its request.
            chan_req = '0;
            step();
            chk("R8", "ack released", int'(chan_ack), 0);
            chk("R8", "hold released", int'(bus_hold_req), 0);
        end
        chan_req = '0; bus_hold_grant = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) step();
        // R1: reset values.
        chan_req = 4'hF; chan_en = 4'hF; bus_hold_grant = 1'b1;
        step();
        chk("R1", "hold_req in reset", int'(bus_hold_req), 0);
        chk("R1", "ack in reset", int'(chan_ack), 0);
        chan_req = '0; chan_en = '0; bus_hold_grant = 1'b0;
        rst_n = 1'b1;
        step();
        chk("R1", "hold_req after reset", int'(bus_hold_req), 0);
        // R6: just after reset, rotating mode searches channel 0 first.
        rotate_mode = 1'b1; chan_en = 4'hF; chan_req = 4'b1001;
        step();
        bus_hold_grant = 1'b1;
        step();
        chk("R6", "post-reset rotate start", int'(chan_ack), 1);
        // R8: taking the bus back ends the grant even with the request held.
        bus_hold_grant = 1'b0;
        step();
        chk("R8", "ack on grant loss", int'(chan_ack), 0);
        chk("R8", "hold on grant loss", int'(bus_hold_req), 0);
        chan_req = '0;
        step();
        // Exhaustive sweep.
        for (int rot = 0; rot < 2; rot++) begin
            for (int last = 0; last < 4; last++) begin
                for (int en = 0; en < 16; en++) begin
                    for (int rq = 0; rq < 16; rq++) begin
                        one_case(rot[0], last, 4'(en), 4'(rq));
                    end
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule